// File: doc/BRIEF.md
# Multi-Level Transmit Precoder Core

This block precodes a serial bit stream for an eight-level transmit driver on a channel with strong post-cursor interference. Each cycle with `enable` high accepts one data bit and yields one 3-bit symbol code. The first post-cursor is removed in feed-forward fashion from the previous input bit. Post-cursors two to ten are removed by feeding back the block's own earlier 3-bit symbol codes, each scaled by a programmable composite weight. Software computes each composite weight for delay k as h(k) minus h1 times h(k-1). No feedback term is taken from the symbol one period back, so the loop through the quantizer spans two register stages.

A signed weighted sum is formed for every symbol. It is requantized to 3 bits against seven evenly spaced thresholds, and the resulting code both drives the output and enters the decision history. A bypass mode sends the raw bit to the driver at full swing, which allows the channel pulse response to be measured. Weights are loaded through a small write port while the stream is idle.

Top module: `tx_precoder`

## Requirements
- R1: Reset (active-low `rstN`, asynchronous) sets `symOut` to the mid-scale code 4, clears `symValid`, fills every history entry with code 4 and clears all weights to zero.
- R2: For precoded symbol n, the sum is 128·d(n) − h1·d(n−1) + Σ w(k)·q(n−k) for k = 2..10. Here d is the input bit (0/1), q(m) is the unsigned 3-bit code emitted for symbol m, and h1 and w(k) are signed two's-complement values.
- R3: The code is the count of thresholds 32, 64, 96, 128, 160, 192 and 224 that the sum reaches or exceeds (sum ≥ threshold). Any sum below 32, including negative sums, gives 0, and any sum of 224 or more gives 7.
- R4: A symbol accepted at one enable edge appears on `symOut` right after the next enable edge.
- R5: While `enable` is low, no symbol is accepted or emitted, and `symOut` and `symValid` hold their values.
- R6: A write stores the signed 8-bit `cfgData` at `cfgAddr`, where address 1 holds h1 and address k (2..10) holds w(k). Writes to addresses 0 and 11..15 change no weight.
- R7: A write presented while `enable` is high is ignored.
- R8: A symbol accepted with `precodeOn` low is emitted as code 7 for bit 1 and code 0 for bit 0. That code enters the history like any other code.
- R9: `symValid` rises with the eleventh emitted symbol after reset and stays high until the next reset.
- R10: d(n−1) is the previously accepted bit, kept across idle periods, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | One symbol accepted and the pipeline advanced per high cycle |
| dataIn | input | 1 | Input data bit |
| precodeOn | input | 1 | 1 = precode this symbol, 0 = bypass |
| cfgWr | input | 1 | Weight write strobe |
| cfgAddr | input | 4 | Weight address (1 = h1, 2..10 = feedback delay) |
| cfgData | input | 8 | Signed weight value |
| symOut | output | 3 | Symbol code for the eight-level driver |
| symValid | output | 1 | History holds only real decisions |

## Verification
The code for a symbol is due one enable edge after that symbol is accepted. The bench therefore checks the previous symbol's expected code, computed by a reference recurrence, at the falling edge that follows each new enable edge. During idle stretches the bench samples at every falling edge and expects the last emitted code and flag to be unchanged. The valid flag is compared against the emitted-symbol index, expected high from index 10 onward. The effect of weight writes is seen in the first symbol accepted after the write edge, so ignored writes show up as code mismatches in the following symbols.

// File: rtl/txp_pkg.sv
package txp_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic capture;   // accept a new input bit into stage 1
    logic emit;      // quantize stage 1 and emit a code
    logic cfgLoad;   // a weight write is allowed this cycle
  } strobe_t;

endpackage

// File: rtl/txp_coef_bank.sv
module txp_coef_bank #(
  parameter int NUM_TAPS = 10,
  parameter int COEF_W   = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgLoad,
  input  logic [ADDR_W-1:0]            cfgAddr,
  input  logic [COEF_W-1:0]            cfgData,
  output logic [NUM_TAPS*COEF_W-1:0]   coefFlat
);

  // slot i holds the weight for address i+1 (slot 0 = first post-cursor)
  generate
    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_reg
      logic [COEF_W-1:0] regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                     regQ <= '0;
        else if (cfgLoad && cfgAddr == ADDR_W'(i + 1)) regQ <= cfgData;
      end
      assign coefFlat[i*COEF_W +: COEF_W] = regQ;
    end
  endgenerate

  // R6: writes to unmapped addresses leave every weight untouched
  a_r6_stray_addr: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && (cfgAddr == '0 || cfgAddr > ADDR_W'(NUM_TAPS))) |=> $stable(coefFlat));

endmodule

// File: rtl/txp_ctrl.sv
module txp_ctrl
  import txp_pkg::*;
#(
  parameter int SETTLE = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    cfgWr,
  output strobe_t strb,
  output logic    symValid
);

  localparam int CNT_W = $clog2(SETTLE + 1);

  logic             s1Full;
  logic [CNT_W-1:0] emitCnt;

  assign strb = '{capture: enable, emit: enable & s1Full, cfgLoad: cfgWr & ~enable};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Full   <= 1'b0;
      emitCnt  <= '0;
      symValid <= 1'b0;
    end else begin
      if (enable) s1Full <= 1'b1;
      if (strb.emit) begin
        symValid <= (emitCnt == CNT_W'(SETTLE));
        if (emitCnt != CNT_W'(SETTLE)) emitCnt <= emitCnt + 1'b1;
      end
    end
  end

  // R9: once set, the flag stays until reset
  a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    symValid |=> symValid);

  // R5: idle cycles do not move the flag
  a_r5_valid_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(symValid));

endmodule

// File: rtl/txp_datapath.sv
module txp_datapath
  import txp_pkg::*;
#(
  parameter int NUM_TAPS    = 10,
  parameter int COEF_W      = 8,
  parameter int CODE_W      = 3,
  parameter int DATA_WEIGHT = 128,
  parameter int FS_LOG2     = 8,
  parameter int ACC_W       = 17
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    strb,
  input  logic                       dataIn,
  input  logic                       precodeOn,
  input  logic [NUM_TAPS*COEF_W-1:0] coefFlat,
  output logic [CODE_W-1:0]          symOut
);

  localparam int LEVELS = 1 << CODE_W;
  localparam int HIST_D = NUM_TAPS - 1;               // delays 2..NUM_TAPS
  localparam int STEP   = (1 << FS_LOG2) >> CODE_W;
  localparam int PROD_W = COEF_W + CODE_W + 1;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(LEVELS / 2);

  logic [CODE_W-1:0]        hist [HIST_D];            // hist[0] = code two symbols back at capture
  logic signed [PROD_W-1:0] prod [HIST_D];
  logic signed [ACC_W-1:0]  accNext, accQ;
  logic signed [COEF_W-1:0] h1;
  logic                     prevBit, s1Bit, s1Bypass;
  logic [LEVELS-2:0]        thermo;
  logic [CODE_W-1:0]        qCode, emitCode;

  assign h1 = coefFlat[COEF_W-1:0];

  // one signed product per feedback delay
  generate
    for (genvar j = 0; j < HIST_D; j++) begin : g_tap
      logic signed [COEF_W-1:0] w;
      logic signed [CODE_W:0]   dec;
      assign w       = coefFlat[(j+1)*COEF_W +: COEF_W];
      assign dec     = $signed({1'b0, hist[j]});
      assign prod[j] = PROD_W'(w) * PROD_W'(dec);
    end
  endgenerate

  always_comb begin
    accNext = dataIn ? ACC_W'(DATA_WEIGHT) : '0;
    if (prevBit) accNext = accNext - ACC_W'(h1);
    for (int j = 0; j < HIST_D; j++) accNext = accNext + ACC_W'(prod[j]);
  end

  // flash-style requantizer: thermometer compare, then count
  generate
    for (genvar t = 1; t < LEVELS; t++) begin : g_thr
      localparam logic signed [ACC_W-1:0] THR = ACC_W'(t * STEP);
      assign thermo[t-1] = (accQ >= THR);
    end
  endgenerate

  always_comb begin
    qCode = '0;
    for (int i = 0; i < LEVELS - 1; i++) qCode = qCode + CODE_W'(thermo[i]);
  end

  assign emitCode = s1Bypass ? {CODE_W{s1Bit}} : qCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit  <= 1'b0;
      s1Bit    <= 1'b0;
      s1Bypass <= 1'b0;
      accQ     <= '0;
      symOut   <= MID_CODE;
      for (int j = 0; j < HIST_D; j++) hist[j] <= MID_CODE;
    end else begin
      if (strb.capture) begin
        accQ     <= accNext;
        prevBit  <= dataIn;
        s1Bit    <= dataIn;
        s1Bypass <= !precodeOn;
      end
      if (strb.emit) begin
        symOut  <= emitCode;
        hist[0] <= emitCode;
        for (int j = 1; j < HIST_D; j++) hist[j] <= hist[j-1];
      end
    end
  end

  // R5: no emit strobe, no output change
  a_r5_code_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.emit |=> $stable(symOut));

  // R8: bypassed symbols leave at full swing
  a_r8_bypass_swing: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && s1Bypass) |=> (symOut == '0 || symOut == '1));

  // R3: sums at or above the top threshold give the top code
  a_r3_top_sat: assert property (@(posedge clk) disable iff (!rstN)
    (strb.emit && !s1Bypass && accQ >= ACC_W'((LEVELS-1) * STEP)) |=> (symOut == CODE_W'(LEVELS-1)));

  // R4: the newest history entry is the code just emitted
  a_r4_hist_tracks: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> (hist[0] == symOut));

endmodule

// File: rtl/tx_precoder.sv
module tx_precoder
  import txp_pkg::*;
#(
  parameter int NUM_TAPS    = 10,
  parameter int COEF_W      = 8,
  parameter int CODE_W      = 3,
  parameter int DATA_WEIGHT = 128,
  parameter int FS_LOG2     = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           enable,
  input  logic                           dataIn,
  input  logic                           precodeOn,
  input  logic                           cfgWr,
  input  logic [$clog2(NUM_TAPS+1)-1:0]  cfgAddr,
  input  logic [COEF_W-1:0]              cfgData,
  output logic [CODE_W-1:0]              symOut,
  output logic                           symValid
);

  localparam int ADDR_W = $clog2(NUM_TAPS + 1);
  localparam int ACC_W  = COEF_W + CODE_W + $clog2(NUM_TAPS) + 2;

  strobe_t                    strb;
  logic [NUM_TAPS*COEF_W-1:0] coefFlat;

  txp_ctrl #(.SETTLE(NUM_TAPS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWr(cfgWr),
    .strb(strb), .symValid(symValid)
  );

  txp_coef_bank #(.NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rstN(rstN), .cfgLoad(strb.cfgLoad), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .coefFlat(coefFlat)
  );

  txp_datapath #(.NUM_TAPS(NUM_TAPS), .COEF_W(COEF_W), .CODE_W(CODE_W),
                 .DATA_WEIGHT(DATA_WEIGHT), .FS_LOG2(FS_LOG2), .ACC_W(ACC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .precodeOn(precodeOn),
    .coefFlat(coefFlat), .symOut(symOut)
  );

  // R7: a write offered during streaming changes no weight
  a_r7_busy_write: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && enable) |=> $stable(coefFlat));

endmodule

// File: tb/test_tx_precoder.sv
module test_tx_precoder;

  logic       clk = 1'b0, rstN = 1'b0, enable = 1'b0, dataIn = 1'b0;
  logic       precodeOn = 1'b1, cfgWr = 1'b0;
  logic [3:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic [2:0] symOut;
  logic       symValid;

  int chkCnt = 0, failCnt = 0;
  bit done = 1'b0;

  // reference state
  int cf [1:10];
  int hq [1:10];
  int prevB, symIdx, pendCode, lastOut;
  bit pendValid, havePend, lastValid;

  // {precodeOn, bit}
  localparam logic [1:0] VEC [0:23] = '{
    2'b11, 2'b11, 2'b10, 2'b11, 2'b10, 2'b10, 2'b11, 2'b01,
    2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b01, 2'b01,
    2'b10, 2'b11, 2'b10, 2'b00, 2'b11, 2'b10, 2'b11, 2'b11
  };

  always #5 clk = ~clk;

  tx_precoder i_tx_precoder (
    .clk(clk), .rstN(rstN), .enable(enable), .dataIn(dataIn), .precodeOn(precodeOn),
    .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .symOut(symOut), .symValid(symValid)
  );

  task automatic check(string tag, int act, int exp);
    chkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int quant(int a);
    int c = 0;
    for (int t = 1; t < 8; t++) if (a >= t * 32) c++;
    return c;
  endfunction

  task automatic modelReset();
    for (int k = 1; k <= 10; k++) begin cf[k] = 0; hq[k] = 4; end
    prevB = 0; symIdx = 0; havePend = 1'b0; lastOut = 4; lastValid = 1'b0;
  endtask

  // drive at a falling edge, check the previous symbol at the next falling edge
  task automatic sendSym(bit b, bit pre, string tag, bit busyWr = 1'b0, int wa = 0, int wd = 0);
    int code, acc;
    if (!pre) code = b ? 7 : 0;
    else begin
      acc = (b ? 128 : 0) - (prevB != 0 ? cf[1] : 0);
      for (int k = 2; k <= 10; k++) acc += cf[k] * hq[k];
      code = quant(acc);
    end
    for (int j = 10; j >= 2; j--) hq[j] = hq[j-1];
    hq[1] = code;
    prevB = b;
    enable = 1'b1; dataIn = b; precodeOn = pre;
    cfgWr = busyWr; cfgAddr = 4'(wa); cfgData = 8'(wd);
    @(posedge clk); @(negedge clk);
    cfgWr = 1'b0;
    if (havePend) begin
      check(tag, int'(symOut), pendCode);
      check("R9", int'(symValid), int'(pendValid));
      lastOut = pendCode; lastValid = pendValid;
    end
    pendCode = code; pendValid = (symIdx >= 10); havePend = 1'b1; symIdx++;
  endtask

  task automatic idle(int n);
    enable = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      check("R5", int'(symOut), lastOut);
      check("R5", int'(symValid), int'(lastValid));
    end
  endtask

  task automatic wrCoef(int a, int d);
    enable = 1'b0; cfgWr = 1'b1; cfgAddr = 4'(a); cfgData = 8'(d);
    @(posedge clk); @(negedge clk);
    cfgWr = 1'b0;
    if (a >= 1 && a <= 10) cf[a] = d;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    check("R1", int'(symOut), 4);
    check("R1", int'(symValid), 0);

    // R1: history starts at mid-scale (w2 = 30 exposes it)
    wrCoef(2, 30);
    sendSym(1'b1, 1'b1, "R1");
    sendSym(1'b0, 1'b1, "R1");
    sendSym(1'b1, 1'b1, "R1");

    // R6: full weight set plus stray addresses
    wrCoef(1, 40);  wrCoef(2, -20); wrCoef(3, 12); wrCoef(4, -7);
    wrCoef(5, 9);   wrCoef(6, -4);  wrCoef(7, 3);  wrCoef(8, -2);
    wrCoef(9, 5);   wrCoef(10, -3);
    wrCoef(0, 100); wrCoef(11, 100); wrCoef(15, -100);

    // R2 / R4 / R8 main stream
    for (int v = 0; v < 24; v++)
      sendSym(VEC[v][0], VEC[v][1], VEC[v][1] ? "R2/R4/R6" : "R8");

    // R5: freeze, then reload a weight while idle
    idle(4);
    wrCoef(2, 60);
    sendSym(1'b0, 1'b1, "R10");
    sendSym(1'b1, 1'b1, "R10");
    idle(3);
    sendSym(1'b0, 1'b1, "R10");

    // R7: write while streaming must be dropped
    sendSym(1'b1, 1'b1, "R7", 1'b1, 1, -128);
    sendSym(1'b1, 1'b1, "R7", 1'b1, 3, 127);
    sendSym(1'b0, 1'b1, "R7");
    sendSym(1'b1, 1'b1, "R7");

    // R3: threshold edges with only the first post-cursor active
    idle(1);
    for (int k = 2; k <= 10; k++) wrCoef(k, 0);
    wrCoef(1, 96);  sendSym(1'b1, 1'b1, "R3"); sendSym(1'b1, 1'b1, "R3");
    wrCoef(1, 97);  sendSym(1'b1, 1'b1, "R3"); sendSym(1'b1, 1'b1, "R3");
    wrCoef(1, -95); sendSym(1'b1, 1'b1, "R3"); sendSym(1'b1, 1'b1, "R3");
    wrCoef(1, -96); sendSym(1'b1, 1'b1, "R3"); sendSym(1'b1, 1'b1, "R3");
    wrCoef(1, 127); sendSym(1'b1, 1'b1, "R3"); sendSym(1'b0, 1'b1, "R3");
    wrCoef(2, 127); sendSym(1'b0, 1'b0, "R8"); sendSym(1'b1, 1'b0, "R8");
    sendSym(1'b1, 1'b1, "R3"); sendSym(1'b1, 1'b1, "R3"); sendSym(1'b0, 1'b1, "R3");

    // R1: reset in mid-stream
    enable = 1'b0;
    rstN = 1'b0;
    #1;
    check("R1", int'(symOut), 4);
    check("R1", int'(symValid), 0);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    wrCoef(3, 25);
    for (int i = 0; i < 14; i++) sendSym(1'(i % 3 == 0), 1'b1, "R1/R9");
    sendSym(1'b0, 1'b1, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
      $finish;
    end
  end

endmodule